// File: doc/BRIEF.md
# Display Line and Status Sequencer

This block keeps the raster timing of a display controller. A cycle counter runs through each scanline, and a line counter runs through each frame. From these two counts it works out the current display phase: horizontal blank, object scan, pixel transfer, or vertical blank. It also compares the line number against a value that software programs.

It has a status register that holds the phase, the compare match and four interrupt-source enables. From these it raises a vertical-blank interrupt request and a status interrupt request. It also gives a one-cycle strobe at the start of every line, which a transfer engine can use to pace copies during horizontal blank.

A single enable input, taken from the display control register, starts and stops the whole sequencer. Register writes use a plain write strobe with a register select and carry no handshake. Pixel fetch and drawing belong to other blocks.

Top module: `lcd_raster_seq`

## Requirements
- R1: Each line lasts 114 clock cycles while enabled. The line counter (`line_o`) then advances by one and wraps from 153 to 0. The first enabled cycle after a stop is cycle 0 of line 0.
- R2: On lines 144 to 153 the mode field (`stat_o[1:0]`) reads 1.
- R3: `vblank_irq` is high for exactly one cycle: the first cycle of line 144.
- R4: On lines 0 to 143 the mode field reads 0 for in-line cycles 0 to 50, 2 for cycles 51 to 70, and 3 for cycles 71 to 113.
- R5: `stat_o[2]` is 1 exactly when `line_o` equals the compare register `cmp_o`.
- R6: Four status interrupt sources exist, each gated by its own enable:
  - `stat_o[6]` gates the compare match.
  - `stat_o[5]` gates mode 2.
  - `stat_o[4]` gates mode 1.
  - `stat_o[3]` gates the line-start strobe.
  
  With all four enables clear, `stat_irq` never rises.
- R7: `stat_irq` is a one-cycle pulse on the rising edge of the OR of the enabled sources. A source that becomes true while another is already true gives no new pulse.
- R8: A write with `wr_sel`=0 loads only `stat_o[6:3]` from `wr_data[6:3]`. `stat_o[7]` always reads 0, and `stat_o[2:0]` cannot be written.
- R9: `hblank_strobe` is high for exactly one cycle, the first cycle of every line. This includes vertical-blank lines and the wrap to line 0.
- R10: While `disp_en` is 0, the line and cycle counters are held at 0 and the mode reads 0. In that state `vblank_irq`, `stat_irq` and `hblank_strobe` stay 0.
- R11: A write with `wr_sel`=1 loads `wr_data` into the compare register, which reads back on `cmp_o` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_en | input | 1 | Display enable from the control register |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: status register, 1: compare register |
| wr_data | input | 8 | Write data |
| line_o | output | 8 | Current line number |
| cmp_o | output | 8 | Line-compare register |
| stat_o | output | 8 | Status: enables [6:3], match [2], mode [1:0] |
| vblank_irq | output | 1 | Vertical-blank interrupt request pulse |
| stat_irq | output | 1 | Status interrupt request pulse |
| hblank_strobe | output | 1 | One-cycle pulse at the start of each line |

## Verification
The bench probes the mode edges at cycles 50/51 and 70/71, where an off-by-one in the decode would show object scan one cycle early or late. It also probes the line 143/144 and 153/0 transitions, where a faulty wrap would count to 154 or fire the vertical-blank request on the wrong line.

It enables the mode-1 and line-start sources together across vertical blank. A sequencer that pulsed on each source, instead of on the combined edge, would raise a second status request at line 145.

It also writes all ones to the status register to show that the mode and match bits cannot be forced. Finally, it stops the display in mid-frame with every enable set, to show that the counters return to zero and no request escapes.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_SCAN   = 2'd2,
    MODE_XFER   = 2'd3
  } lcd_mode_e;

  // index of each source enable inside the 4-bit enable field (status bits 6:3)
  localparam int IE_HBL  = 0;
  localparam int IE_VBL  = 1;
  localparam int IE_SCAN = 2;
  localparam int IE_CMP  = 3;
endpackage

// File: rtl/lcd_dot_counter.sv
module lcd_dot_counter #(
  parameter int CYC_PER_LINE = 114,
  parameter int VIS_LINES    = 144,
  parameter int TOTAL_LINES  = 154,
  parameter int CW           = $clog2(CYC_PER_LINE),
  parameter int LW           = $clog2(TOTAL_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] cyc_o,
  output logic [LW-1:0] line_o,
  output logic          hb_o,
  output logic          vb_o
);
  localparam logic [CW-1:0] CYC_LAST  = CW'(CYC_PER_LINE - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(TOTAL_LINES - 1);
  localparam logic [LW-1:0] VIS_LAST  = LW'(VIS_LINES - 1);
  localparam logic [LW-1:0] VB_LINE   = LW'(VIS_LINES);

  logic [CW-1:0] cyc_q;
  logic [LW-1:0] line_q;
  logic          hb_q, vb_q;
  logic          eol;

  assign eol = (cyc_q == CYC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      line_q <= '0;
      hb_q   <= 1'b0;
      vb_q   <= 1'b0;
    end else if (!en) begin
      cyc_q  <= '0;
      line_q <= '0;
      hb_q   <= 1'b0;
      vb_q   <= 1'b0;
    end else begin
      hb_q <= eol;
      vb_q <= eol && (line_q == VIS_LAST);
      if (eol) begin
        cyc_q  <= '0;
        line_q <= (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign cyc_o  = cyc_q;
  assign line_o = line_q;
  assign hb_o   = hb_q;
  assign vb_o   = vb_q;

  AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= CYC_LAST); // R1
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && eol && line_q == LINE_LAST) |=> (line_q == '0)); // R1
  AST_VB_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    vb_q |-> (line_q == VB_LINE && cyc_q == '0)); // R3
  AST_HB_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    hb_q |-> (cyc_q == '0)); // R9
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (line_q == '0 && cyc_q == '0 && !hb_q && !vb_q)); // R10
endmodule

// File: rtl/lcd_mode_decode.sv
module lcd_mode_decode
  import lcd_seq_pkg::*;
#(
  parameter int VIS_LINES  = 144,
  parameter int SCAN_START = 51,
  parameter int XFER_START = 71,
  parameter int CW         = 7,
  parameter int LW         = 8,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cyc,
  input  logic [LW-1:0] line,
  input  logic [DW-1:0] cmp,
  output lcd_mode_e     mode_o,
  output logic          coin_o
);
  localparam logic [LW-1:0] VB_LINE = LW'(VIS_LINES);
  localparam logic [CW-1:0] SCAN_C  = CW'(SCAN_START);
  localparam logic [CW-1:0] XFER_C  = CW'(XFER_START);

  always_comb begin
    if (!en)                  mode_o = MODE_HBLANK;
    else if (line >= VB_LINE) mode_o = MODE_VBLANK;
    else if (cyc < SCAN_C)    mode_o = MODE_HBLANK;
    else if (cyc < XFER_C)    mode_o = MODE_SCAN;
    else                      mode_o = MODE_XFER;
  end

  assign coin_o = ((DW)'(line) == cmp);

  AST_VB_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && line >= VB_LINE) |-> (mode_o == MODE_VBLANK)); // R2
  AST_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (mode_o == MODE_HBLANK)); // R10
endmodule

// File: rtl/lcd_stat_irq.sv
module lcd_stat_irq
  import lcd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       wr_stat,
  input  logic [3:0] wr_ie,
  input  lcd_mode_e  mode,
  input  logic       coin,
  input  logic       hb,
  output logic [7:0] stat_o,
  output logic       irq_o
);
  logic [3:0] ie_q;
  logic       src_any, src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ie_q <= '0;
    else if (wr_stat) ie_q <= wr_ie;
  end

  assign src_any = en && ((ie_q[IE_CMP]  && coin) ||
                          (ie_q[IE_SCAN] && mode == MODE_SCAN) ||
                          (ie_q[IE_VBL]  && mode == MODE_VBLANK) ||
                          (ie_q[IE_HBL]  && hb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src_any;
  end

  assign irq_o  = src_any && !src_q;
  assign stat_o = {1'b0, ie_q, coin, mode};

  AST_IE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (stat_o[6:3] == $past(wr_ie))); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R7
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq_o); // R10
endmodule

// File: rtl/lcd_raster_seq.sv
module lcd_raster_seq
  import lcd_seq_pkg::*;
#(
  parameter int CYC_PER_LINE = 114,
  parameter int VIS_LINES    = 144,
  parameter int TOTAL_LINES  = 154,
  parameter int SCAN_START   = 51,
  parameter int XFER_START   = 71,
  parameter int DW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_en,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] line_o,
  output logic [DW-1:0] cmp_o,
  output logic [7:0]    stat_o,
  output logic          vblank_irq,
  output logic          stat_irq,
  output logic          hblank_strobe
);
  localparam int CW = $clog2(CYC_PER_LINE);
  localparam int LW = $clog2(TOTAL_LINES);

  logic [CW-1:0] cyc;
  logic [LW-1:0] line;
  logic          hb, vb, coin;
  lcd_mode_e     mode;
  logic [DW-1:0] cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cmp_q <= '0;
    else if (wr_en && wr_sel)  cmp_q <= wr_data;
  end

  lcd_dot_counter #(
    .CYC_PER_LINE(CYC_PER_LINE), .VIS_LINES(VIS_LINES),
    .TOTAL_LINES(TOTAL_LINES), .CW(CW), .LW(LW)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(disp_en),
    .cyc_o(cyc), .line_o(line), .hb_o(hb), .vb_o(vb)
  );

  lcd_mode_decode #(
    .VIS_LINES(VIS_LINES), .SCAN_START(SCAN_START), .XFER_START(XFER_START),
    .CW(CW), .LW(LW), .DW(DW)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .en(disp_en), .cyc(cyc), .line(line),
    .cmp(cmp_q), .mode_o(mode), .coin_o(coin)
  );

  lcd_stat_irq u_stat (
    .clk(clk), .rst_n(rst_n), .en(disp_en),
    .wr_stat(wr_en && !wr_sel), .wr_ie(wr_data[6:3]),
    .mode(mode), .coin(coin), .hb(hb),
    .stat_o(stat_o), .irq_o(stat_irq)
  );

  assign line_o        = (DW)'(line);
  assign cmp_o         = cmp_q;
  assign vblank_irq    = vb;
  assign hblank_strobe = hb;

  AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (cmp_o == $past(wr_data))); // R11
  AST_COIN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (line_o == cmp_o) |-> stat_o[2]); // R5
  AST_VB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |=> !vblank_irq); // R3
endmodule

// File: tb/tb_lcd_raster_seq.sv
module tb_lcd_raster_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] line_o, cmp_o, stat_o;
  logic       vblank_irq, stat_irq, hblank_strobe;

  int n_cmp = 0;
  int n_bad = 0;
  int k = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcd_raster_seq dut (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .line_o(line_o), .cmp_o(cmp_o),
    .stat_o(stat_o), .vblank_irq(vblank_irq), .stat_irq(stat_irq),
    .hblank_strobe(hblank_strobe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at k=%0d: actual %0d expected %0d", tag, k, act, exp);
    end
  endtask

  // program status enables and compare while stopped, then start at k=0
  task automatic restart(input logic [7:0] st, input logic [7:0] cm);
    @(negedge clk); disp_en = 1'b0; wr_en = 1'b1; wr_sel = 1'b0; wr_data = st;
    @(negedge clk); wr_sel = 1'b1; wr_data = cm;
    @(negedge clk); wr_en = 1'b0; disp_en = 1'b1; k = 0;
  endtask

  task automatic adv(input int target);
    while (k < target) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset;
    chk("R10 reset line", int'(line_o), 0);
    chk("R10 reset stat", int'(stat_o), 8'h04);
    chk("R10 reset vblank", int'(vblank_irq), 0);
    chk("R10 reset statirq", int'(stat_irq), 0);
    chk("R10 reset strobe", int'(hblank_strobe), 0);
  endtask

  task automatic t_modes;
    restart(8'h00, 8'd200);
    chk("R11 cmp readback", int'(cmp_o), 200);
    chk("R1 first line", int'(line_o), 0);
    adv(50);  chk("R4 mode c50", int'(stat_o[1:0]), 0);
    adv(51);  chk("R4 mode c51", int'(stat_o[1:0]), 2);
    adv(70);  chk("R4 mode c70", int'(stat_o[1:0]), 2);
    adv(71);  chk("R4 mode c71", int'(stat_o[1:0]), 3);
    adv(113); chk("R4 mode c113", int'(stat_o[1:0]), 3);
              chk("R9 no strobe c113", int'(hblank_strobe), 0);
    adv(114); chk("R1 line after 114", int'(line_o), 1);
              chk("R4 mode new line", int'(stat_o[1:0]), 0);
              chk("R9 strobe line1", int'(hblank_strobe), 1);
    adv(115); chk("R9 strobe one cycle", int'(hblank_strobe), 0);
  endtask

  task automatic t_frame_merge;
    restart(8'h18, 8'd200);
    adv(143*114 + 113);
    chk("R1 line143", int'(line_o), 143);
    chk("R4 mode line143", int'(stat_o[1:0]), 3);
    chk("R3 no vblank early", int'(vblank_irq), 0);
    adv(144*114);
    chk("R2 mode line144", int'(stat_o[1:0]), 1);
    chk("R3 vblank pulse", int'(vblank_irq), 1);
    chk("R6 mode1 source irq", int'(stat_irq), 1);
    adv(144*114 + 1);
    chk("R3 vblank one cycle", int'(vblank_irq), 0);
    chk("R7 irq one cycle", int'(stat_irq), 0);
    adv(145*114);
    chk("R9 strobe in vblank", int'(hblank_strobe), 1);
    chk("R7 merged no repulse", int'(stat_irq), 0);
    chk("R3 no vblank line145", int'(vblank_irq), 0);
    adv(153*114 + 100);
    chk("R2 line153", int'(line_o), 153);
    chk("R2 mode line153", int'(stat_o[1:0]), 1);
    adv(154*114);
    chk("R1 wrap to 0", int'(line_o), 0);
    chk("R9 strobe at wrap", int'(hblank_strobe), 1);
    chk("R4 mode after wrap", int'(stat_o[1:0]), 0);
  endtask

  task automatic t_scan_irq;
    restart(8'h20, 8'd200);
    adv(50);  chk("R6 scan none c50", int'(stat_irq), 0);
    adv(51);  chk("R6 scan irq c51", int'(stat_irq), 1);
    adv(52);  chk("R7 scan pulse ends", int'(stat_irq), 0);
    adv(71);  chk("R6 no irq mode3", int'(stat_irq), 0);
    adv(165); chk("R6 scan irq line1", int'(stat_irq), 1);
  endtask

  task automatic t_hb_irq;
    restart(8'h08, 8'd200);
    adv(113); chk("R6 hb none before", int'(stat_irq), 0);
    adv(114); chk("R6 hb irq", int'(stat_irq), 1);
    adv(115); chk("R7 hb irq ends", int'(stat_irq), 0);
  endtask

  task automatic t_coin;
    restart(8'h40, 8'd5);
    chk("R11 cmp is 5", int'(cmp_o), 5);
    adv(5*114 - 1);
    chk("R5 no match line4", int'(stat_o[2]), 0);
    chk("R6 no coin irq line4", int'(stat_irq), 0);
    adv(5*114);
    chk("R5 match line5", int'(stat_o[2]), 1);
    chk("R6 coin irq", int'(stat_irq), 1);
    adv(5*114 + 1);
    chk("R7 coin irq ends", int'(stat_irq), 0);
    chk("R5 match holds", int'(stat_o[2]), 1);
    adv(6*114);
    chk("R5 match clears", int'(stat_o[2]), 0);
  endtask

  task automatic t_no_enables;
    int pulses = 0;
    restart(8'h00, 8'd0);
    while (k < 154*114) begin
      if (stat_irq) pulses++;
      adv(k + 1);
    end
    chk("R6 no irq without enables", pulses, 0);
  endtask

  task automatic t_stat_write;
    restart(8'hFF, 8'd200);
    chk("R8 write all ones", int'(stat_o), 8'h78);
    adv(60);
    chk("R8 mode still live", int'(stat_o), 8'h7A);
    restart(8'h87, 8'd200);
    chk("R8 only 6:3 written", int'(stat_o), 8'h00);
  endtask

  task automatic t_disable;
    int bad = 0;
    restart(8'hFF, 8'd0);
    adv(3*114 + 60);
    @(negedge clk); disp_en = 1'b0;
    @(negedge clk);
    chk("R10 line held 0", int'(line_o), 0);
    chk("R10 mode 0 off", int'(stat_o[1:0]), 0);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (line_o != 0 || stat_irq || vblank_irq || hblank_strobe) bad++;
    end
    chk("R10 quiet while off", bad, 0);
    disp_en = 1'b1; k = 0;
    adv(51);
    chk("R1 restart cycle 0", int'(stat_o[1:0]), 2);
    chk("R1 restart line 0", int'(line_o), 0);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_frame_merge();
    t_scan_irq();
    t_hb_irq();
    t_coin();
    t_no_enables();
    t_stat_write();
    t_disable();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule